// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Model

This block is a synthesizable, cycle-level model of a small dynamic memory device. Its storage is a grid of supercells, each `WIDTH` bits wide, organised as `ROWS` rows by `COLS` columns. One narrow address bus carries both coordinates, one after the other. The row number comes first, qualified by a level-sensitive row strobe. The column number follows on the same lines, qualified by a single-cycle column strobe. Opening a row copies that whole row into an internal row buffer. Column accesses then read from that buffer or write into it. The buffer is copied back into the array when the row strobe drops (precharge).

A refresh request takes a row number on the address bus, reads that row into the buffer and writes it straight back. The stored data is left unchanged. A column strobe that arrives while no row is open is rejected and reported on an error output. Read data appears one clock after the column strobe is sampled.

The controller has four named states:
- `ST_IDLE`: no row is open.
- `ST_ACTIVE`: a row is held in the buffer.
- `ST_PRECHARGE`: the buffer is being written back after the row strobe has dropped.
- `ST_REF_WB`: the write-back half of a refresh.

The transitions are:
- IDLE→REF_WB on refresh.
- IDLE→ACTIVE on row strobe.
- ACTIVE→PRECHARGE when the row strobe falls.
- PRECHARGE→IDLE and REF_WB→IDLE unconditionally.

Top module: `mux_addr_dram`

## Requirements
- R1: After reset, `rdata` is 0, `rvalid` and `err` are 0, and every supercell of the array holds 0.
- R2: In the idle state with `refresh` low, a high `row_stb` latches `addr` as the row number, loads that row into the row buffer and opens it. The row stays open while `row_stb` remains high.
- R3: A column strobe with `wr_en` low, on an open row (active state with `row_stb` high), returns the supercell at column `addr` on `rdata` in the next cycle. In that same cycle `rvalid` is high for exactly one cycle.
- R4: A column strobe with `wr_en` high, on an open row, stores `wdata` into the buffered supercell at column `addr`. Later reads of that column in the same open period return the new value.
- R5: When `row_stb` is low in the active state, the device spends one precharge cycle writing the buffer back into the array row, then returns to idle. Data written in the buffer is therefore found in the array after the row is reopened.
- R6: A column strobe that arrives when no row is open (idle, precharge, refresh write-back, or active with `row_stb` already low) raises `err` for one cycle in the next cycle. It leaves `rvalid` low and changes no stored data.
- R7: In idle, `refresh` takes priority over `row_stb`. It reads the row given on `addr` and writes it back over the next cycle, returning to idle two cycles after it is sampled. Stored data is left unchanged.
- R8: Writes made while one row is open leave every other row unchanged.
- R9: While a row is open, changes on `addr` without a strobe do not change which row is open. Column accesses always use the latched row.
- R10: `wr_en` and `wdata` have no effect when no column strobe accompanies them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | max(clog2(ROWS), clog2(COLS)) | Shared row/column address bus |
| row_stb | input | 1 | Row strobe: high opens and holds a row, low precharges |
| col_stb | input | 1 | Column strobe, one access per sampled cycle |
| wr_en | input | 1 | Column access is a write when high |
| refresh | input | 1 | Refresh request for the row on `addr` |
| wdata | input | WIDTH | Write data for a column write |
| rdata | output | WIDTH | Read data, valid the cycle after a column read |
| rvalid | output | 1 | One-cycle pulse marking new `rdata` |
| err | output | 1 | One-cycle pulse after a column strobe with no open row |

## Verification
The hardest situation to reach is a column write that arrives in the precharge cycle. At that moment the buffer still holds freshly written data that is being copied back, and the stray write must neither reach the buffer nor the array. The stimulus writes a known value into an open row and drops `row_stb`. On the very next cycle it presents a column write of a different value. It then reopens the row to confirm that the earlier value survived the write-back. The same approach covers a column strobe issued in the same cycle that `row_stb` falls. Sweeps over every supercell before writes, after writes and after refresh of every row cover the remaining behaviour with expected values derived from the row and column numbers.

// File: rtl/dram_pkg.sv
package dram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ACTIVE    = 2'd1,
        ST_PRECHARGE = 2'd2,
        ST_REF_WB    = 2'd3
    } dram_state_e;

endpackage

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_pkg::*;
#(
    parameter int RAW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           row_stb,
    input  logic           col_stb,
    input  logic           wr_en,
    input  logic           refresh,
    input  logic [RAW-1:0] row_addr,
    output logic           load_row,
    output logic           wb_en,
    output logic           col_wr,
    output logic           col_rd,
    output logic [RAW-1:0] open_row,
    output logic           rvalid,
    output logic           err
);

    dram_state_e state_q, state_d;
    logic        col_ok;
    logic [RAW-1:0] row_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (refresh)      state_d = ST_REF_WB;
                else if (row_stb) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!row_stb) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: state_d = ST_IDLE;
            ST_REF_WB:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs of each state
    always_comb begin
        load_row = 1'b0;
        wb_en    = 1'b0;
        col_ok   = 1'b0;
        unique case (state_q)
            ST_IDLE:      load_row = refresh | row_stb;
            ST_ACTIVE:    col_ok   = row_stb;
            ST_PRECHARGE: wb_en    = 1'b1;
            ST_REF_WB:    wb_en    = 1'b1;
            default:      ;
        endcase
        col_wr = col_stb & col_ok & wr_en;
        col_rd = col_stb & col_ok & ~wr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            rvalid <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (load_row) row_q <= row_addr;
            rvalid <= col_rd;
            err    <= col_stb & ~col_ok;
        end
    end

    assign open_row = row_q;

    // R6
    assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && state_q != ST_ACTIVE) |=> (err && !rvalid))
        else $error("stray_col_err_chk");

    // R3
    assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && !wr_en && state_q == ST_ACTIVE && row_stb) |=> (rvalid && !err))
        else $error("read_valid_chk");

    // R5
    assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !row_stb) |=> (state_q == ST_PRECHARGE) ##1 (state_q == ST_IDLE))
        else $error("precharge_seq_chk");

    // R7
    assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && refresh) |=> (state_q == ST_REF_WB) ##1 (state_q == ST_IDLE))
        else $error("refresh_seq_chk");

    // R9
    assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE) |=> $stable(row_q))
        else $error("open_row_hold_chk");

endmodule

// File: rtl/dram_array.sv
module dram_array #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int RW   = COLS * WIDTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] rd_row,
    output logic [RW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic [RAW-1:0] wr_row,
    input  logic [RW-1:0]  wr_data
);

    logic [ROWS-1:0][RW-1:0] cells_q;
    logic [ROWS-1:0]         row_hit;

    for (genvar g = 0; g < ROWS; g++) begin : g_row_dec
        assign row_hit[g] = wr_en && (wr_row == RAW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_q <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (row_hit[r]) cells_q[r] <= wr_data;
            end
        end
    end

    assign rd_data = cells_q[rd_row];

    // R5
    assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cells_q[$past(wr_row)] == $past(wr_data)))
        else $error("writeback_lands_chk");

    // R8
    assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cells_q))
        else $error("array_quiet_chk");

endmodule

// File: rtl/dram_rowbuf.sv
module dram_rowbuf #(
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int CAW  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int RW   = COLS * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RW-1:0]    load_data,
    input  logic [CAW-1:0]   col,
    input  logic             col_wr,
    input  logic             col_rd,
    input  logic [WIDTH-1:0] wdata,
    output logic [RW-1:0]    row_data,
    output logic [WIDTH-1:0] rdata
);

    logic [COLS-1:0][WIDTH-1:0] buf_q;
    logic [COLS-1:0]            col_hit;

    for (genvar g = 0; g < COLS; g++) begin : g_col_dec
        assign col_hit[g] = col_wr && (col == CAW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (load) begin
            buf_q <= load_data;
        end else begin
            for (int c = 0; c < COLS; c++) begin
                if (col_hit[c]) buf_q[c] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '0;
        else if (col_rd) rdata <= buf_q[col];
    end

    assign row_data = buf_q;

    // R4
    assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && !load) |=> (buf_q[$past(col)] == $past(wdata)))
        else $error("col_write_chk");

    // R10
    assert property (@(posedge clk) disable iff (!rst_n)
        (!col_wr && !load) |=> $stable(buf_q))
        else $error("buf_quiet_chk");

    // R3
    assert property (@(posedge clk) disable iff (!rst_n)
        !col_rd |=> $stable(rdata))
        else $error("rdata_hold_chk");

endmodule

// File: rtl/mux_addr_dram.sv
module mux_addr_dram #(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int WIDTH = 8,
    localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CAW  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int AW   = (RAW > CAW) ? RAW : CAW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             row_stb,
    input  logic             col_stb,
    input  logic             wr_en,
    input  logic             refresh,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             rvalid,
    output logic             err
);

    localparam int RW = COLS * WIDTH;

    logic           load_row, wb_en, col_wr, col_rd;
    logic [RAW-1:0] open_row;
    logic [RW-1:0]  array_rd, buf_row;

    dram_ctrl #(.RAW(RAW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_stb  (row_stb),
        .col_stb  (col_stb),
        .wr_en    (wr_en),
        .refresh  (refresh),
        .row_addr (addr[RAW-1:0]),
        .load_row (load_row),
        .wb_en    (wb_en),
        .col_wr   (col_wr),
        .col_rd   (col_rd),
        .open_row (open_row),
        .rvalid   (rvalid),
        .err      (err)
    );

    dram_array #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (addr[RAW-1:0]),
        .rd_data (array_rd),
        .wr_en   (wb_en),
        .wr_row  (open_row),
        .wr_data (buf_row)
    );

    dram_rowbuf #(.COLS(COLS), .WIDTH(WIDTH)) u_rowbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_row),
        .load_data (array_rd),
        .col       (addr[CAW-1:0]),
        .col_wr    (col_wr),
        .col_rd    (col_rd),
        .wdata     (wdata),
        .row_data  (buf_row),
        .rdata     (rdata)
    );

    // R6
    assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid && err))
        else $error("valid_err_excl_chk");

endmodule

// File: tb/test_mux_addr_dram.sv
`timescale 1ns/1ps
module test_mux_addr_dram;

    localparam int ROWS  = 4;
    localparam int COLS  = 4;
    localparam int WIDTH = 8;
    localparam int AW    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic             row_stb = 1'b0, col_stb = 1'b0, wr_en = 1'b0, refresh = 1'b0;
    logic [WIDTH-1:0] wdata = '0;
    logic [WIDTH-1:0] rdata;
    logic             rvalid, err;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    mux_addr_dram #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) i_mux_addr_dram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .row_stb(row_stb), .col_stb(col_stb),
        .wr_en(wr_en), .refresh(refresh), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .err(err)
    );

    function automatic logic [WIDTH-1:0] pat(int r, int c);
        return WIDTH'((r * 37 + c * 11 + 90) % 256);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic open_row(int r);
        addr = AW'(r); row_stb = 1'b1;
        @(negedge clk);
    endtask

    task automatic close_row();
        row_stb = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic col_write(int c, logic [WIDTH-1:0] d);
        addr = AW'(c); wr_en = 1'b1; wdata = d; col_stb = 1'b1;
        @(negedge clk);
        col_stb = 1'b0; wr_en = 1'b0;
    endtask

    task automatic col_read_chk(int c, logic [WIDTH-1:0] exp, string req);
        addr = AW'(c); wr_en = 1'b0; col_stb = 1'b1;
        @(negedge clk);
        check(rvalid && !err && rdata == exp, req, {rvalid, rdata}, {1'b1, exp});
        col_stb = 1'b0;
    endtask

    task automatic sweep_chk(bit zero, string req);
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++)
                col_read_chk(c, zero ? '0 : pat(r, c), req);
            close_row();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values at the ports
        check(rdata == 0 && !rvalid && !err, "R1", {rvalid, err, rdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rvalid && !err, "R1", {rvalid, err}, 0);

        // R1, R2, R3: all cells read zero after reset
        sweep_chk(1'b1, "R1");

        // R4: write every column, read back while open; R8 checked after
        for (int r = 0; r < ROWS; r++) begin
            open_row(r);
            for (int c = 0; c < COLS; c++) col_write(c, pat(r, c));
            for (int c = COLS - 1; c >= 0; c--) col_read_chk(c, pat(r, c), "R4");
            close_row();
        end
        // R5, R8: every row holds its own pattern after write-back
        sweep_chk(1'b0, "R5");

        // R3: rvalid is a single-cycle pulse
        open_row(1);
        col_read_chk(3, pat(1, 3), "R3");
        @(negedge clk);
        check(!rvalid, "R3", rvalid, 0);
        check(rdata == pat(1, 3), "R3", rdata, pat(1, 3));

        // R9: address changes alone do not move the open row
        addr = 2'd3; @(negedge clk);
        addr = 2'd0; @(negedge clk);
        col_read_chk(2, pat(1, 2), "R9");
        close_row();

        // R10: wr_en and wdata without col_stb do nothing
        open_row(2);
        addr = 2'd0; wr_en = 1'b1; wdata = 8'hFF;
        repeat (2) @(negedge clk);
        check(!rvalid && !err, "R10", {rvalid, err}, 0);
        wr_en = 1'b0;
        col_read_chk(0, pat(2, 0), "R10");
        close_row();

        // R6: column write in idle
        addr = 2'd1; wr_en = 1'b1; wdata = 8'h00; col_stb = 1'b1;
        @(negedge clk);
        check(err && !rvalid, "R6", {err, rvalid}, 2);
        col_stb = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check(!err, "R6", err, 0);

        // R6: column write in the precharge cycle
        open_row(3);
        col_write(1, 8'hC3);
        row_stb = 1'b0;
        @(negedge clk);
        addr = 2'd1; wr_en = 1'b1; wdata = 8'h11; col_stb = 1'b1;
        @(negedge clk);
        check(err && !rvalid, "R6", {err, rvalid}, 2);
        col_stb = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        // R6: column strobe in the same cycle row_stb falls
        open_row(3);
        addr = 2'd2; wr_en = 1'b1; wdata = 8'h22; col_stb = 1'b1; row_stb = 1'b0;
        @(negedge clk);
        check(err && !rvalid, "R6", {err, rvalid}, 2);
        col_stb = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        open_row(3);
        col_read_chk(1, 8'hC3, "R6");
        col_read_chk(2, pat(3, 2), "R6");
        col_write(1, pat(3, 1));
        close_row();

        // R7: refresh every row, also with row_stb raised, data kept
        for (int r = 0; r < ROWS; r++) begin
            addr = AW'(r); refresh = 1'b1; row_stb = (r == 2);
            @(negedge clk);
            refresh = 1'b0; row_stb = 1'b0;
            @(negedge clk);
            check(!rvalid && !err, "R7", {rvalid, err}, 0);
        end
        // R6: column strobe during refresh write-back
        addr = 2'd0; refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0; col_stb = 1'b1; wr_en = 1'b1; wdata = 8'h44;
        @(negedge clk);
        check(err, "R6", err, 1);
        col_stb = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        sweep_chk(1'b0, "R7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule